// File: doc/BRIEF.md
# Interrupt Redirection Input Controller

This block gathers interrupt requests from a parameterised set of input pins, 16 or 24, and turns each accepted request into a single delivery message. A message carries a vector, a delivery mode and a bitmap of target CPUs. Every pin has its own redirection entry, written through a simple register port. The entry holds the vector, a mask bit, the trigger kind (edge or level), the delivery mode and a destination set.

Fixed mode sends the message to the whole destination set. Lowest-priority mode narrows the set to the one CPU whose live priority input is lowest. External mode does not use the vector in the entry. It asks a legacy interrupt controller for the vector through an acknowledge pulse and then waits, for a bounded time, for a vector strobe.

Pins that request in the same cycle are put in order by a rotating pointer. The output is a valid/ready channel that can carry one message per cycle. A level-triggered pin stays blocked after delivery until an end-of-interrupt with its vector arrives.

Top module: `irq_redirect`

## Requirements
- R1: After reset no message is valid, the acknowledge output is low, and every entry is masked, so a pin event that comes before any write produces no message.
- R2: A write puts `cfg_data` into entry `cfg_idx` with this layout: vector in bits 7:0, mask in bit 8, trigger in bit 9 (1 = level), delivery mode in bits 11:10 (0 fixed, 1 lowest-priority, 2 external, 3 treated as masked) and destination bitmap from bit 12 upward. A rising edge on an unmasked edge-triggered fixed-mode pin yields one message with that vector, mode 0 and the entry's destination bitmap.
- R3: A rising edge that arrives while its pin is masked is discarded, and it is not delivered when the pin is later unmasked.
- R4: An entry in fixed or lowest-priority mode whose vector is below 16 behaves as masked and produces no message.
- R5: In lowest-priority mode the message destination has exactly one bit set. That bit is the CPU in the destination set whose `cpu_prio` field is lowest. On a tie the lowest-numbered CPU wins.
- R6: A level-triggered pin that has been delivered sends nothing more while its input stays high. An end-of-interrupt with a different vector leaves it blocked. An end-of-interrupt with the entry's vector unblocks it, and the pin then delivers again if its input is still high.
- R7: When several pins are pending, a rotating pointer picks the first pending pin at or above the pin after the last one granted, wrapping around. One message leaves per cycle.
- R8: While `msg_valid` is high and `msg_ready` is low, the message stays valid and its fields do not change.
- R9: For an external-mode pin, `ext_ack` is high for exactly one cycle. A vector that then arrives with `ext_vec_valid` is delivered with mode 2 and the entry's destination bitmap.
- R10: If no vector strobe arrives within `EXT_TMO` cycles after the acknowledge, the request is dropped without a message, and other pins are served afterwards.
- R11: A vector below 16 returned by the external controller is dropped, so no message ever carries a vector below 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NPIN | Interrupt request pins |
| cfg_we | input | 1 | Entry write strobe |
| cfg_idx | input | IDXW | Entry index for the write |
| cfg_data | input | 12+NCPU | Entry contents (layout in R2) |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vec | input | 8 | Vector being ended |
| cpu_prio | input | NCPU*PRIO_W | Live priority of each CPU, CPU 0 in the low field |
| msg_valid | output | 1 | Message valid |
| msg_ready | input | 1 | Message accepted by the receiver |
| msg_vec | output | 8 | Message vector |
| msg_mode | output | 2 | Message delivery mode |
| msg_dest | output | NCPU | Message destination bitmap |
| ext_ack | output | 1 | Acknowledge pulse to the legacy controller |
| ext_vec_valid | input | 1 | Vector strobe from the legacy controller |
| ext_vec | input | 8 | Vector from the legacy controller |

## Verification
The bench builds the block with 24 pins and 4 CPUs, so pins above 15 are driven and lowest-priority selection can produce a tie among several CPUs. It lowers `EXT_TMO` to 8, which lets the external-controller timeout expire within a short test, and it checks that the block recovers afterwards. Pin indices on both sides of the rotating pointer make the wrap-around order observable.

// File: rtl/irqr_pkg.sv
package irqr_pkg;

  typedef enum logic [1:0] {
    DM_FIXED  = 2'd0,
    DM_LOWEST = 2'd1,
    DM_EXTERN = 2'd2,
    DM_RSVD   = 2'd3
  } dmode_e;

  // Bit order matches the low 12 bits of the configuration word.
  typedef struct packed {
    dmode_e     mode;
    logic       trig;
    logic       mask;
    logic [7:0] vec;
  } rte_t;

  localparam logic [7:0] VEC_MIN = 8'd16;

  function automatic logic rte_live(rte_t e);
    return !e.mask && ((e.mode == DM_EXTERN) ||
                       ((e.mode != DM_RSVD) && (e.vec >= VEC_MIN)));
  endfunction

endpackage

// File: rtl/redir_table.sv
module redir_table
  import irqr_pkg::*;
#(
  parameter int NPIN = 24,
  parameter int NCPU = 4,
  parameter int IDXW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDXW-1:0]      wr_idx,
  input  logic [12+NCPU-1:0]   wr_data,
  output rte_t                 ent_o [NPIN],
  output logic [NCPU-1:0]      dst_o [NPIN]
);

  for (genvar i = 0; i < NPIN; i++) begin : g_ent
    rte_t            ent_q;
    logic [NCPU-1:0] dst_q;
    logic            wen;

    assign wen = wr_en && (wr_idx == IDXW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '{mode: DM_FIXED, trig: 1'b0, mask: 1'b1, vec: 8'd0};
        dst_q <= '0;
      end else if (wen) begin
        ent_q <= rte_t'(wr_data[11:0]);
        dst_q <= wr_data[12 +: NCPU];
      end
    end

    assign ent_o[i] = ent_q;
    assign dst_o[i] = dst_q;
  end

endmodule

// File: rtl/pin_detect.sv
module pin_detect #(
  parameter int NPIN = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] irq_i,
  input  logic [NPIN-1:0] live_i,
  input  logic [NPIN-1:0] lvl_i,
  input  logic [NPIN-1:0] grant_i,
  input  logic [NPIN-1:0] eoi_hit_i,
  input  logic [NPIN-1:0] drop_i,
  output logic [NPIN-1:0] pend_o
);

  logic [NPIN-1:0] prev_q, pend_q, rirr_q;
  logic [NPIN-1:0] prev_d, pend_d, rirr_d;
  logic [NPIN-1:0] rise, evt;

  always_comb begin
    rise   = irq_i & ~prev_q;
    evt    = live_i & ((~lvl_i & rise) | (lvl_i & irq_i & ~rirr_q & ~pend_q));
    prev_d = irq_i;
    pend_d = (pend_q & ~grant_i) | evt;
    rirr_d = (rirr_q & ~eoi_hit_i & ~drop_i) | (grant_i & lvl_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
      rirr_q <= '0;
    end else begin
      prev_q <= prev_d;
      pend_q <= pend_d;
      rirr_q <= rirr_d;
    end
  end

  assign pend_o = pend_q;

  for (genvar i = 0; i < NPIN; i++) begin : g_chk
    // R3: an edge on a masked pin never becomes pending
    p_masked_edge_lost_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rise[i] && !live_i[i] && !pend_q[i]) |=> !pend_q[i]);
    // R6: a blocked level pin stays idle until its end-of-interrupt
    p_rirr_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_i[i] && rirr_q[i] && !pend_q[i] && !eoi_hit_i[i] && !drop_i[i]) |=> !pend_q[i]);
  end

endmodule

// File: rtl/lp_pick.sv
module lp_pick #(
  parameter int NCPU   = 4,
  parameter int PRIO_W = 4
) (
  input  logic [NCPU-1:0]        dest_i,
  input  logic [NCPU*PRIO_W-1:0] prio_i,
  output logic [NCPU-1:0]        sel_o
);

  localparam int SW = (NCPU > 1) ? $clog2(NCPU) : 1;

  logic              found;
  logic [PRIO_W-1:0] best;
  logic [SW-1:0]     bidx;

  // Descending scan with <= lets the lowest index win ties.
  always_comb begin
    found = 1'b0;
    best  = '0;
    bidx  = '0;
    for (int i = NCPU - 1; i >= 0; i--) begin
      if (dest_i[i] && (!found || (prio_i[i*PRIO_W +: PRIO_W] <= best))) begin
        found = 1'b1;
        best  = prio_i[i*PRIO_W +: PRIO_W];
        bidx  = SW'(i);
      end
    end
    sel_o = '0;
    if (found) sel_o[bidx] = 1'b1;
  end

endmodule

// File: rtl/irq_redirect.sv
module irq_redirect
  import irqr_pkg::*;
#(
  parameter int NPIN    = 24,
  parameter int NCPU    = 4,
  parameter int PRIO_W  = 4,
  parameter int EXT_TMO = 64,
  localparam int IDXW   = $clog2(NPIN),
  localparam int CFG_W  = 12 + NCPU
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPIN-1:0]        irq_in,
  input  logic                   cfg_we,
  input  logic [IDXW-1:0]        cfg_idx,
  input  logic [CFG_W-1:0]       cfg_data,
  input  logic                   eoi_valid,
  input  logic [7:0]             eoi_vec,
  input  logic [NCPU*PRIO_W-1:0] cpu_prio,
  output logic                   msg_valid,
  input  logic                   msg_ready,
  output logic [7:0]             msg_vec,
  output logic [1:0]             msg_mode,
  output logic [NCPU-1:0]        msg_dest,
  output logic                   ext_ack,
  input  logic                   ext_vec_valid,
  input  logic [7:0]             ext_vec
);

  localparam int CW = $clog2(EXT_TMO + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ACK, ST_WAIT} xst_e;

  rte_t            ent [NPIN];
  logic [NCPU-1:0] dst [NPIN];
  logic [NPIN-1:0] live, lvl, eoi_hit, pend, grant, drop;
  logic [NCPU-1:0] lp_sel;

  // Register state and next-state values.
  xst_e            st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [IDXW-1:0] xpin_q, xpin_d;
  logic [IDXW-1:0] rr_q, rr_d;
  logic            mv_q, mv_d;
  logic [7:0]      vec_q, vec_d;
  dmode_e          mode_q, mode_d;
  logic [NCPU-1:0] dest_q, dest_d;

  logic            slot_free, can_grant, found;
  logic [IDXW-1:0] pidx;
  rte_t            sel_ent;
  logic [NCPU-1:0] sel_dst;

  redir_table #(.NPIN(NPIN), .NCPU(NCPU), .IDXW(IDXW)) u_tab (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_idx  (cfg_idx),
    .wr_data (cfg_data),
    .ent_o   (ent),
    .dst_o   (dst)
  );

  always_comb begin
    for (int i = 0; i < NPIN; i++) begin
      live[i]    = rte_live(ent[i]);
      lvl[i]     = ent[i].trig;
      eoi_hit[i] = eoi_valid && ent[i].trig && (ent[i].vec == eoi_vec);
    end
  end

  pin_detect #(.NPIN(NPIN)) u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_i     (irq_in),
    .live_i    (live),
    .lvl_i     (lvl),
    .grant_i   (grant),
    .eoi_hit_i (eoi_hit),
    .drop_i    (drop),
    .pend_o    (pend)
  );

  // Rotating search from the pointer, wrapping at NPIN.
  always_comb begin
    found = 1'b0;
    pidx  = '0;
    for (int k = 0; k < NPIN; k++) begin
      int idx;
      idx = int'(rr_q) + k;
      if (idx >= NPIN) idx = idx - NPIN;
      if (!found && pend[idx]) begin
        found = 1'b1;
        pidx  = IDXW'(idx);
      end
    end
  end

  assign slot_free = !mv_q || msg_ready;
  assign can_grant = slot_free && (st_q == ST_IDLE);
  assign sel_ent   = ent[pidx];
  assign sel_dst   = dst[pidx];

  always_comb begin
    grant = '0;
    if (can_grant && found) grant[pidx] = 1'b1;
  end

  lp_pick #(.NCPU(NCPU), .PRIO_W(PRIO_W)) u_lp (
    .dest_i (sel_dst),
    .prio_i (cpu_prio),
    .sel_o  (lp_sel)
  );

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    xpin_d = xpin_q;
    rr_d   = rr_q;
    mv_d   = mv_q && !msg_ready;
    vec_d  = vec_q;
    mode_d = mode_q;
    dest_d = dest_q;
    drop   = '0;

    if (can_grant && found) begin
      rr_d = (pidx == IDXW'(NPIN - 1)) ? '0 : pidx + 1'b1;
      if (sel_ent.mode == DM_EXTERN) begin
        st_d   = ST_ACK;
        xpin_d = pidx;
      end else begin
        mv_d   = 1'b1;
        vec_d  = sel_ent.vec;
        mode_d = sel_ent.mode;
        dest_d = (sel_ent.mode == DM_LOWEST) ? lp_sel : sel_dst;
      end
    end

    unique case (st_q)
      ST_ACK: begin
        st_d  = ST_WAIT;
        cnt_d = '0;
      end
      ST_WAIT: begin
        if (ext_vec_valid) begin
          st_d = ST_IDLE;
          if (ext_vec >= VEC_MIN) begin
            mv_d   = 1'b1;
            vec_d  = ext_vec;
            mode_d = DM_EXTERN;
            dest_d = dst[xpin_q];
          end else begin
            drop[xpin_q] = 1'b1;
          end
        end else if (cnt_q == CW'(EXT_TMO - 1)) begin
          st_d         = ST_IDLE;
          drop[xpin_q] = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      xpin_q <= '0;
      rr_q   <= '0;
      mv_q   <= 1'b0;
      vec_q  <= '0;
      mode_q <= DM_FIXED;
      dest_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      xpin_q <= xpin_d;
      rr_q   <= rr_d;
      mv_q   <= mv_d;
      vec_q  <= vec_d;
      mode_q <= mode_d;
      dest_q <= dest_d;
    end
  end

  assign msg_valid = mv_q;
  assign msg_vec   = vec_q;
  assign msg_mode  = mode_q;
  assign msg_dest  = dest_q;
  assign ext_ack   = (st_q == ST_ACK);

  p_vec_floor_r11: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_vec >= VEC_MIN));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=>
      (msg_valid && $stable(msg_vec) && $stable(msg_mode) && $stable(msg_dest)));
  p_lp_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && (msg_mode == DM_LOWEST)) |-> ($countones(msg_dest) <= 1));
  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ack |=> !ext_ack);
  p_grant_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  p_tmo_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT) |-> (cnt_q < CW'(EXT_TMO)));

endmodule

// File: tb/sim_irq_redirect.sv
module sim_irq_redirect;

  localparam int NPIN = 24, NCPU = 4, PW = 4, TMO = 8;

  logic            clk, rst_n;
  logic [NPIN-1:0] irq_in;
  logic            cfg_we;
  logic [4:0]      cfg_idx;
  logic [15:0]     cfg_data;
  logic            eoi_valid;
  logic [7:0]      eoi_vec;
  logic [15:0]     cpu_prio;
  logic            msg_valid, msg_ready;
  logic [7:0]      msg_vec;
  logic [1:0]      msg_mode;
  logic [3:0]      msg_dest;
  logic            ext_ack, ext_vec_valid;
  logic [7:0]      ext_vec;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  irq_redirect #(.NPIN(NPIN), .NCPU(NCPU), .PRIO_W(PW), .EXT_TMO(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .eoi_valid(eoi_valid), .eoi_vec(eoi_vec), .cpu_prio(cpu_prio),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vec(msg_vec), .msg_mode(msg_mode),
    .msg_dest(msg_dest), .ext_ack(ext_ack), .ext_vec_valid(ext_vec_valid), .ext_vec(ext_vec)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic wcfg(input int idx, input logic [7:0] vec, input bit mask, input bit lvl,
                      input logic [1:0] mode, input logic [3:0] dest);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 5'(idx); cfg_data = {dest, mode, lvl, mask, vec};
    @(negedge clk);
    cfg_we = 0;
  endtask

  // Polls at negedges for a message; leaves one negedge past it.
  task automatic expect_msg(input string req, input logic [7:0] vec, input logic [1:0] mode,
                            input logic [3:0] dest);
    bit seen = 0;
    for (int c = 0; c < 12 && !seen; c++) begin
      if (msg_valid) seen = 1; else @(negedge clk);
    end
    chk(seen, req, 32'(msg_valid), 1);
    if (seen) begin
      chk(msg_vec == vec, req, 32'(msg_vec), 32'(vec));
      chk(msg_mode == mode, req, 32'(msg_mode), 32'(mode));
      chk(msg_dest == dest, req, 32'(msg_dest), 32'(dest));
      @(negedge clk);
    end
  endtask

  task automatic expect_none(input string req, input int cycles);
    bit any = 0;
    for (int c = 0; c < cycles; c++) begin
      if (msg_valid) any = 1;
      @(negedge clk);
    end
    chk(!any, req, 32'(any), 0);
  endtask

  task automatic pulse_eoi(input logic [7:0] v);
    @(negedge clk); eoi_valid = 1; eoi_vec = v;
    @(negedge clk); eoi_valid = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!msg_valid, "R1 msg_valid", 32'(msg_valid), 0);
    chk(!ext_ack, "R1 ext_ack", 32'(ext_ack), 0);
    irq_in[0] = 1;
    expect_none("R1 unwritten entry masked", 6);
    irq_in[0] = 0;
  endtask

  task automatic t_rr();
    wcfg(2, 8'h22, 0, 0, 2'd0, 4'h1);
    wcfg(5, 8'h25, 0, 0, 2'd0, 4'h2);
    wcfg(1, 8'h21, 0, 0, 2'd0, 4'h1);
    wcfg(7, 8'h27, 0, 0, 2'd0, 4'h4);
    @(negedge clk); irq_in[2] = 1; irq_in[5] = 1;
    expect_msg("R7 first pin2", 8'h22, 2'd0, 4'h1);
    chk(msg_valid && msg_vec == 8'h25, "R7 back-to-back pin5", 32'(msg_vec), 32'h25);
    expect_msg("R7 second pin5", 8'h25, 2'd0, 4'h2);
    irq_in[2] = 0; irq_in[5] = 0;
    @(negedge clk); irq_in[1] = 1; irq_in[7] = 1;
    expect_msg("R7 wrap pin7 first", 8'h27, 2'd0, 4'h4);
    expect_msg("R7 wrap pin1 second", 8'h21, 2'd0, 4'h1);
    irq_in[1] = 0; irq_in[7] = 0;
  endtask

  task automatic t_fixed_high();
    wcfg(20, 8'hA0, 0, 0, 2'd0, 4'hB);
    @(negedge clk); irq_in[20] = 1;
    expect_msg("R2 fixed pin20", 8'hA0, 2'd0, 4'hB);
    expect_none("R2 single message per edge", 5);
    irq_in[20] = 0;
  endtask

  task automatic t_masked();
    wcfg(3, 8'h33, 1, 0, 2'd0, 4'h1);
    @(negedge clk); irq_in[3] = 1;
    expect_none("R3 masked edge", 4);
    wcfg(3, 8'h33, 0, 0, 2'd0, 4'h1);
    expect_none("R3 lost after unmask", 6);
    irq_in[3] = 0;
    @(negedge clk); irq_in[3] = 1;
    expect_msg("R3 new edge after unmask", 8'h33, 2'd0, 4'h1);
    irq_in[3] = 0;
  endtask

  task automatic t_lowvec();
    wcfg(6, 8'h0F, 0, 0, 2'd0, 4'h1);
    @(negedge clk); irq_in[6] = 1;
    expect_none("R4 vector below 16", 6);
    irq_in[6] = 0;
  endtask

  task automatic t_lowest();
    wcfg(12, 8'h5C, 0, 0, 2'd1, 4'hE);
    cpu_prio = {4'd3, 4'd3, 4'd5, 4'd0};
    @(negedge clk); irq_in[12] = 1;
    expect_msg("R5 tie to cpu2", 8'h5C, 2'd1, 4'h4);
    irq_in[12] = 0;
    cpu_prio = {4'd2, 4'd9, 4'd1, 4'd7};
    @(negedge clk); irq_in[12] = 1;
    expect_msg("R5 min cpu1", 8'h5C, 2'd1, 4'h2);
    irq_in[12] = 0;
  endtask

  task automatic t_level();
    wcfg(4, 8'h40, 0, 1, 2'd0, 4'h1);
    @(negedge clk); irq_in[4] = 1;
    expect_msg("R6 level first", 8'h40, 2'd0, 4'h1);
    expect_none("R6 blocked while high", 6);
    pulse_eoi(8'h41);
    expect_none("R6 wrong EOI vector", 6);
    pulse_eoi(8'h40);
    expect_msg("R6 redeliver after EOI", 8'h40, 2'd0, 4'h1);
    irq_in[4] = 0;
    pulse_eoi(8'h40);
    expect_none("R6 low after EOI", 6);
  endtask

  task automatic t_backpressure();
    msg_ready = 0;
    @(negedge clk); irq_in[20] = 1;
    for (int c = 0; c < 10 && !msg_valid; c++) @(negedge clk);
    for (int c = 0; c < 3; c++) begin
      chk(msg_valid && msg_vec == 8'hA0 && msg_dest == 4'hB, "R8 held", 32'(msg_vec), 32'hA0);
      @(negedge clk);
    end
    msg_ready = 1;
    @(negedge clk);
    chk(!msg_valid, "R8 accepted", 32'(msg_valid), 0);
    irq_in[20] = 0;
  endtask

  // Waits for the acknowledge, checks it is a pulse, then answers or not.
  task automatic ext_run(input string req, input bit answer, input logic [7:0] v);
    bit seen = 0;
    for (int c = 0; c < 10 && !seen; c++) begin
      if (ext_ack) seen = 1; else @(negedge clk);
    end
    chk(seen, req, 32'(ext_ack), 1);
    @(negedge clk);
    chk(!ext_ack, "R9 ack one cycle", 32'(ext_ack), 0);
    if (answer) begin
      ext_vec_valid = 1; ext_vec = v;
      @(negedge clk);
      ext_vec_valid = 0;
    end
  endtask

  task automatic t_extern();
    wcfg(9, 8'h00, 0, 0, 2'd2, 4'h6);
    @(negedge clk); irq_in[9] = 1;
    ext_run("R9 ack seen", 1, 8'h77);
    expect_msg("R9 external vector", 8'h77, 2'd2, 4'h6);
    irq_in[9] = 0;
    @(negedge clk); irq_in[9] = 1;
    ext_run("R10 ack seen", 0, 8'h00);
    expect_none("R10 timeout drops", TMO + 6);
    irq_in[9] = 0;
    wcfg(10, 8'h3A, 0, 0, 2'd0, 4'h8);
    @(negedge clk); irq_in[10] = 1;
    expect_msg("R10 recovery", 8'h3A, 2'd0, 4'h8);
    irq_in[10] = 0;
    @(negedge clk); irq_in[9] = 1;
    ext_run("R11 ack seen", 1, 8'h05);
    expect_none("R11 low external vector dropped", 6);
    irq_in[9] = 0;
  endtask

  initial begin
    rst_n = 0; irq_in = '0; cfg_we = 0; cfg_idx = '0; cfg_data = '0;
    eoi_valid = 0; eoi_vec = '0; cpu_prio = '0; msg_ready = 1;
    ext_vec_valid = 0; ext_vec = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_rr();
    t_fixed_high();
    t_masked();
    t_lowvec();
    t_lowest();
    t_level();
    t_backpressure();
    t_extern();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

endmodule